// File: doc/BRIEF.md
# Stereo Complementary Crossfade Mixer

This block blends two stereo sample pairs into one stereo output. One pair comes from a buffer played backwards and the other is the live signal moving forward. A single unsigned fade coefficient weights the backward pair. The bitwise complement of the same coefficient weights the forward pair. Both products are summed and the upper half of the sum becomes the output sample. The left and right channels always use the same coefficient in a given frame.

An upstream sequencer lowers the coefficient by a fixed step each audio frame to move smoothly from backward playback to live playback. At a 44.1 kHz frame rate the fade lasts 65536 / (step × 44.1) milliseconds. Each accepted frame produces one result after a single registered stage.

Top module: `xfade_mix`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and both mixed outputs are 0 until the first accepted frame.
- R2: `out_valid` in each cycle equals `in_valid` from the previous cycle, so the latency is one cycle.
- R3: When `in_valid` is 1, `mix_l` on the next cycle is bits [31:16] of `rev_l × fade + fwd_l × (~fade)`. The samples are two's-complement signed and `fade` is unsigned, so the result is the floor of the weighted sum divided by 65536.
- R4: The right channel uses the same rule with `rev_r`, `fwd_r` and the same `fade` value. Equal left and right inputs give equal outputs.
- R5: With `fade` = 0x0000 the output follows the forward sample. The forward weight is 65535, so a positive sample comes out one code lower.
- R6: With `fade` = 0xFFFF the output follows the backward sample under the same rule.
- R7: When `in_valid` is 0 both mixed outputs keep their previous values, whatever the other inputs do.
- R8: Full-scale inputs never wrap. If both samples are -32768 the result is -32768 for any `fade`. If both are +32767 the result is +32766.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input frame strobe |
| rev_l | input | 16 | Backward-playback left sample, signed |
| rev_r | input | 16 | Backward-playback right sample, signed |
| fwd_l | input | 16 | Live left sample, signed |
| fwd_r | input | 16 | Live right sample, signed |
| fade | input | 16 | Unsigned weight for the backward pair |
| out_valid | output | 1 | Output frame strobe |
| mix_l | output | 16 | Mixed left sample, signed |
| mix_r | output | 16 | Mixed right sample, signed |

## Verification
The assertions assume that the inputs are stable at each rising edge. The full-scale check also assumes that the two samples on a channel really are equal whenever the bench presents that case. The stimulus changes inputs only at falling edges. It builds the identical-channel and full-scale frames explicitly, so that the L/R equality check and the no-wrap check see frames that meet their preconditions. Idle cycles change every data input on purpose, so that the hold check sees a real attempt to disturb the outputs.

// File: rtl/xfade_mix.sv
module xfade_mix #(
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] rev_l,
  input  logic signed [SW-1:0] rev_r,
  input  logic signed [SW-1:0] fwd_l,
  input  logic signed [SW-1:0] fwd_r,
  input  logic        [CW-1:0] fade,
  output logic                 out_valid,
  output logic signed [SW-1:0] mix_l,
  output logic signed [SW-1:0] mix_r
);
  localparam int AW = SW + CW + 2;
  localparam logic signed [SW-1:0] MINV = {1'b1, {(SW-1){1'b0}}};
  localparam logic signed [SW-1:0] MAXV = {1'b0, {(SW-1){1'b1}}};

  function automatic logic signed [SW-1:0] blend(
    input logic signed [SW-1:0] r,
    input logic signed [SW-1:0] f,
    input logic        [CW-1:0] k
  );
    logic signed [AW-1:0] acc;
    acc = AW'(r) * AW'($signed({1'b0, k})) + AW'(f) * AW'($signed({1'b0, ~k}));
    return SW'(acc >>> CW);
  endfunction

  logic signed [SW-1:0] nxt_l, nxt_r;
  assign nxt_l = blend(rev_l, fwd_l, fade);
  assign nxt_r = blend(rev_r, fwd_r, fade);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mix_l     <= '0;
      mix_r     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        mix_l <= nxt_l;
        mix_r <= nxt_r;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(mix_l) && $stable(mix_r));

  // R4
  same_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rev_l == rev_r && fwd_l == fwd_r) |=> mix_l == mix_r);

  // R8
  no_wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rev_l == MINV && fwd_l == MINV) |=> mix_l == MINV);

  // R8
  no_wrap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rev_r == MAXV && fwd_r == MAXV) |=> mix_r == MAXV - 1);
endmodule

// File: tb/sim_xfade_mix.sv
module sim_xfade_mix;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] rev_l = '0, rev_r = '0, fwd_l = '0, fwd_r = '0;
  logic [15:0] fade = '0;
  logic out_valid;
  logic signed [15:0] mix_l, mix_r;

  xfade_mix u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .rev_l(rev_l), .rev_r(rev_r), .fwd_l(fwd_l), .fwd_r(fwd_r),
    .fade(fade), .out_valid(out_valid), .mix_l(mix_l), .mix_r(mix_r));

  always #4 clk = ~clk;

  int runs = 0, fails = 0;
  bit done = 0;
  string tag = "R1";
  int m_valid = 0, m_l = 0, m_r = 0;

  function automatic int ref_mix(int r, int f, int k);
    longint acc;
    acc = longint'(r) * longint'(k) + longint'(f) * longint'(65535 - k);
    return int'(acc >>> 16);
  endfunction

  task automatic check(string req, int act, int exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int v, int rl, int rr, int fl, int fr, int k);
    @(negedge clk);
    check("R2", int'(out_valid), m_valid);
    check({tag, " left"}, int'(mix_l), m_l);
    check({tag, " right"}, int'(mix_r), m_r);
    in_valid = v[0];
    rev_l = 16'(rl); rev_r = 16'(rr); fwd_l = 16'(fl); fwd_r = 16'(fr);
    fade = 16'(k);
    if (v != 0) begin
      m_l = ref_mix(rl, fl, k);
      m_r = ref_mix(rr, fr, k);
    end
    m_valid = v;
  endtask

  function automatic int rs();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R1 valid", int'(out_valid), 0);
      check("R1 left", int'(mix_l), 0);
      check("R1 right", int'(mix_r), 0);
    end
    rst_n = 1'b1;
    tag = "R1";
    step(0, 1000, -1000, 500, 7, 123);
    step(0, 2, 3, 4, 5, 6);
    tag = "R5";
    step(1, 12000, -9000, 1000, -1000, 0);
    for (int i = 0; i < 20; i++) step(1, rs(), rs(), rs(), rs(), 0);
    tag = "R6";
    step(1, 1000, -1000, 12000, -9000, 65535);
    for (int i = 0; i < 20; i++) step(1, rs(), rs(), rs(), rs(), 65535);
    tag = "R3";
    for (int i = 0; i < 200; i++) step(1, rs(), rs(), rs(), rs(), int'($urandom_range(0, 65535)));
    for (int k = 65535; k > 0; k -= 128) step(1, 20000, -20000, -15000, 15000, k);
    tag = "R4";
    for (int i = 0; i < 30; i++) begin
      int a = rs(), b = rs();
      step(1, a, a, b, b, int'($urandom_range(0, 65535)));
    end
    tag = "R8";
    step(1, -32768, 32767, -32768, 32767, 0);
    step(1, -32768, 32767, -32768, 32767, 65535);
    step(1, -32768, 32767, -32768, 32767, 32768);
    step(1, 32767, -32768, -32768, 32767, 65535);
    step(1, 32767, -32768, -32768, 32767, 0);
    tag = "R7";
    step(1, 5000, -7000, 300, 400, 40000);
    for (int i = 0; i < 25; i++) step(0, rs(), rs(), rs(), rs(), int'($urandom_range(0, 65535)));
    for (int i = 0; i < 30; i++) step(i % 3 == 0, rs(), rs(), rs(), rs(), int'($urandom_range(0, 65535)));
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule